// File: doc/BRIEF.md
# Masked-Latch Interrupt Status Controller

This block gathers one-cycle request pulses from a set of peripheral sources and keeps them in a status register until software acknowledges them. A second register, the enable mask, decides which sources may latch at all. A request arriving while its enable bit is 0 is discarded for good; it does not wait for the bit to be set later. A single level-sensitive interrupt line to the processor is raised while any status bit is set.

Software reaches both registers over a small synchronous register bus. A write to the status register acknowledges pending sources by writing 1 to their bits. A write to the enable register programs it directly, limited to the bits named writable. Offsets that are not decoded read back as all ones and ignore writes. Masking is applied only on the way into status. Bits already latched keep the processor line asserted even if their enable bit is cleared afterwards.

Top module: `irq_latch_ctrl`

## Requirements
- R1: On reset, status reads 0x00000000, the enable register reads the parameter MASK_RST (default 0x00000000) and irq_o is 0.
- R2: A request pulse on source n with enable bit n at 1 sets status bit n at the next clock edge. Status is read at offset 0x00, bit n being source n.
- R3: A request on a source whose enable bit is 0 in that cycle leaves status unchanged, and a later setting of that enable bit does not set the status bit.
- R4: A write to offset 0x00 clears every status bit whose write-data bit and writable-mask bit are both 1 and leaves every other bit unchanged.
- R5: When a request for bit n and a clear of bit n fall in the same cycle, status bit n is 1 afterwards.
- R6: A write to offset 0x04 loads write data ANDed with WR_MASK (default 0x000007FF, 11 sources on bits 0 to 10) into the enable register, and bits outside WR_MASK read back as 0.
- R7: irq_o is a register that equals, one cycle later, whether any status bit was 1. It is not gated by the enable register.
- R8: A read with ren_i high at any offset other than 0x00 and 0x04 returns 0xFFFFFFFF, and a write there changes neither register.
- R9: rdata_o is 0 whenever ren_i is 0. Otherwise it shows the current register value in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | NUM_SRC | One-cycle request pulse per source |
| addr_i | input | ADDR_W | Byte offset of the register access |
| wen_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| ren_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Registered interrupt line to the processor |

## Verification
Read data is due in the cycle the read is presented. Status and enable changes become visible through a read one edge after the cycle of the request or write. irq_o follows status by one more edge, so it lags a request by two edges. The bench drives each access just after a falling edge and compares rdata_o 1 ns later, before the rising edge. It then advances a reference model at the rising edge and compares irq_o 1 ns after that edge, which keeps each result in its own cycle.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] RD_UNMAPPED = 32'hFFFF_FFFF;
    localparam int OFF_STATUS = 'h00;
    localparam int OFF_ENABLE = 'h04;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ENABLE = 2'd2
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e           sel;
        logic               wr;
        logic               rd;
        logic [DATA_W-1:0]  wdata;
    } bus_op_t;

    function automatic reg_sel_e offset_to_sel(input int unsigned off);
        if (off == OFF_STATUS) return SEL_STATUS;
        if (off == OFF_ENABLE) return SEL_ENABLE;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_latch_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wen_i,
    input  logic              ren_i,
    input  logic [DATA_W-1:0] wdata_i,
    output bus_op_t           op_o
);
    always_comb begin
        op_o.sel   = offset_to_sel(int'(unsigned'(addr_i)));
        op_o.wr    = wen_i;
        op_o.rd    = ren_i;
        op_o.wdata = wdata_i;
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_latch_pkg::*;
#(
    parameter int                NUM_SRC  = 11,
    parameter logic [DATA_W-1:0] WR_MASK  = 32'h0000_07FF,
    parameter logic [DATA_W-1:0] MASK_RST = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  bus_op_t            op_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] enable_o
);
    localparam logic [NUM_SRC-1:0] WMASK    = WR_MASK[NUM_SRC-1:0];
    localparam logic [NUM_SRC-1:0] EN_RESET = MASK_RST[NUM_SRC-1:0] & WMASK;

    logic [NUM_SRC-1:0] status_q, enable_q;
    logic [NUM_SRC-1:0] ack_bits, accepted;

    always_comb begin
        ack_bits = '0;
        if (op_i.wr && op_i.sel == SEL_STATUS)
            ack_bits = op_i.wdata[NUM_SRC-1:0] & WMASK;
        accepted = req_i & enable_q;
    end

    // Clear first, then OR in new requests: a same-cycle request survives.
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= EN_RESET;
        end else begin
            status_q <= (status_q & ~ack_bits) | accepted;
            if (op_i.wr && op_i.sel == SEL_ENABLE)
                enable_q <= op_i.wdata[NUM_SRC-1:0] & WMASK;
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive #(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] status_i,
    output logic               irq_o
);
    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |status_i;
    end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
    import irq_latch_pkg::*;
#(
    parameter int                NUM_SRC  = 11,
    parameter int                ADDR_W   = 8,
    parameter logic [DATA_W-1:0] WR_MASK  = 32'h0000_07FF,
    parameter logic [DATA_W-1:0] MASK_RST = 32'h0000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wen_i,
    input  logic [31:0]        wdata_i,
    input  logic               ren_i,
    output logic [31:0]        rdata_o,
    output logic               irq_o
);
    bus_op_t            op;
    logic [NUM_SRC-1:0] status_q, mask_q;

    irq_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr_i (addr_i),
        .wen_i  (wen_i),
        .ren_i  (ren_i),
        .wdata_i(wdata_i),
        .op_o   (op)
    );

    irq_status_bank #(
        .NUM_SRC (NUM_SRC),
        .WR_MASK (WR_MASK),
        .MASK_RST(MASK_RST)
    ) bank_i (
        .clk     (clk),
        .rst     (rst),
        .req_i   (irq_req_i),
        .op_i    (op),
        .status_o(status_q),
        .enable_o(mask_q)
    );

    irq_line_drive #(.NUM_SRC(NUM_SRC)) line_i (
        .clk     (clk),
        .rst     (rst),
        .status_i(status_q),
        .irq_o   (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        if (op.rd) begin
            unique case (op.sel)
                SEL_STATUS: rdata_o = DATA_W'(status_q);
                SEL_ENABLE: rdata_o = DATA_W'(mask_q);
                default:    rdata_o = RD_UNMAPPED;
            endcase
        end
    end
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
    parameter int          NUM_SRC = 11,
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] WR_MASK = 32'h0000_07FF
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq_req_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic               wen_i,
    input logic [31:0]        wdata_i,
    input logic               ren_i,
    input logic [31:0]        rdata_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] mask_q
);
    localparam logic [NUM_SRC-1:0] WM = WR_MASK[NUM_SRC-1:0];

    logic               hit_stat, hit_mask, unmapped;
    logic [NUM_SRC-1:0] granted, clr_bits;
    assign hit_stat = (addr_i == ADDR_W'(0));
    assign hit_mask = (addr_i == ADDR_W'(4));
    assign unmapped = !hit_stat && !hit_mask;
    assign granted  = irq_req_i & mask_q;
    assign clr_bits = (wen_i && hit_stat) ? (wdata_i[NUM_SRC-1:0] & WM & ~granted) : '0;

    p_line_lag_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|status_q)));

    p_no_masked_set_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(granted)) == '0));

    p_req_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (granted != '0) |=> ((status_q & $past(granted)) == $past(granted)));

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_bits != '0) |=> ((status_q & $past(clr_bits)) == '0));

    p_mask_range_r6: assert property (@(posedge clk) disable iff (rst)
        (ren_i && hit_mask) |-> ((rdata_o & ~WR_MASK) == 32'h0));

    p_unmapped_read_r8: assert property (@(posedge clk) disable iff (rst)
        (ren_i && unmapped) |-> (rdata_o == 32'hFFFF_FFFF));

    p_idle_read_r9: assert property (@(posedge clk) disable iff (rst)
        !ren_i |-> (rdata_o == 32'h0));
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W),
    .WR_MASK(WR_MASK)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .irq_req_i(irq_req_i),
    .addr_i   (addr_i),
    .wen_i    (wen_i),
    .wdata_i  (wdata_i),
    .ren_i    (ren_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .status_q (status_q),
    .mask_q   (mask_q)
);

// File: tb/irq_latch_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_latch_ctrl_tb_top;
    localparam int          NS  = 11;
    localparam logic [31:0] WMK = 32'h0000_07FF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] req = '0;
    logic [7:0]    addr = '0;
    logic          wen = 1'b0;
    logic [31:0]   wdata = '0;
    logic          ren = 1'b0;
    logic [31:0]   rdata;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] m_status = '0;
    logic [31:0] m_mask   = '0;
    logic        m_irq    = 1'b0;

    always #2 clk = ~clk;

    irq_latch_ctrl dut_i (
        .clk(clk), .rst(rst), .irq_req_i(req), .addr_i(addr), .wen_i(wen),
        .wdata_i(wdata), .ren_i(ren), .rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a, input logic r);
        if (!r) return 32'h0;
        if (a == 8'h00) return m_status;
        if (a == 8'h04) return m_mask;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] exp_status(input logic [31:0] s, input logic [31:0] m,
                                               input logic [31:0] rq, input logic w,
                                               input logic [7:0] a, input logic [31:0] d);
        logic [31:0] clr;
        clr = (w && a == 8'h00) ? (d & WMK) : 32'h0;
        return (s & ~clr) | (rq & m);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input logic [NS-1:0] rq, input logic [7:0] a,
                       input logic w, input logic [31:0] d, input logic r);
        logic [31:0] ns;
        @(negedge clk);
        req = rq; addr = a; wen = w; wdata = d; ren = r;
        #1;
        check(r ? tag : "R9", rdata, exp_read(a, r));
        @(posedge clk);
        ns = exp_status(m_status, m_mask, 32'(rq), w, a, d);
        m_irq = |m_status;
        if (w && a == 8'h04) m_mask = d & WMK;
        m_status = ns;
        #1;
        check("R7", 32'(irq), 32'(m_irq));
    endtask

    task automatic idle(); cyc("R9", '0, 8'h00, 1'b0, 32'h0, 1'b0); endtask

    initial begin
        logic done = 1'b0;
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    n_fail++; n_checks++;
                    $display("FAIL watchdog: actual timeout expected completion");
                    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                    $finish;
                end
            end
        join_none

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1", 32'(irq), 32'h0);
        // R1 reset values
        cyc("R1", '0, 8'h00, 1'b0, 0, 1'b1);
        cyc("R1", '0, 8'h04, 1'b0, 0, 1'b1);
        // R6 mask write limited to writable bits
        cyc("R6", '0, 8'h04, 1'b1, 32'hFFFF_FFFF, 1'b0);
        cyc("R6", '0, 8'h04, 1'b0, 0, 1'b1);
        check("R6", rdata, 32'h0000_07FF);
        // R2 set bit 3, R7 line follows
        cyc("R2", NS'(11'h008), 8'h00, 1'b0, 0, 1'b0);
        cyc("R2", '0, 8'h00, 1'b0, 0, 1'b1);
        check("R2", rdata, 32'h8);
        idle();
        check("R7", 32'(irq), 32'h1);
        // R4 clear bit 3 only
        cyc("R2", NS'(11'h011), 8'h00, 1'b0, 0, 1'b0);
        cyc("R4", '0, 8'h00, 1'b1, 32'h0000_0008, 1'b0);
        cyc("R4", '0, 8'h00, 1'b0, 0, 1'b1);
        check("R4", rdata, 32'h11);
        // R5 request beats same-cycle clear
        cyc("R5", NS'(11'h004), 8'h00, 1'b1, 32'h0000_0004, 1'b0);
        cyc("R5", '0, 8'h00, 1'b0, 0, 1'b1);
        check("R5", rdata, 32'h15);
        cyc("R4", '0, 8'h00, 1'b1, 32'hFFFF_FFFF, 1'b0);
        idle(); idle();
        check("R7", 32'(irq), 32'h0);
        // R3 masked request dropped, not pending
        cyc("R3", '0, 8'h04, 1'b1, 32'h0000_0001, 1'b0);
        cyc("R3", NS'(11'h020), 8'h00, 1'b0, 0, 1'b0);
        cyc("R3", '0, 8'h04, 1'b1, 32'h0000_07FF, 1'b0);
        cyc("R3", '0, 8'h00, 1'b0, 0, 1'b1);
        check("R3", rdata, 32'h0);
        // R7 latched bit keeps line high after masking
        cyc("R7", NS'(11'h001), 8'h00, 1'b0, 0, 1'b0);
        cyc("R7", '0, 8'h04, 1'b1, 32'h0, 1'b0);
        idle(); idle();
        check("R7", 32'(irq), 32'h1);
        // R8 unmapped offsets
        cyc("R8", '0, 8'h08, 1'b1, 32'hFFFF_FFFF, 1'b1);
        check("R8", rdata, 32'hFFFF_FFFF);
        cyc("R8", '0, 8'h00, 1'b0, 0, 1'b1);
        check("R8", rdata, 32'h1);
        cyc("R8", '0, 8'h04, 1'b0, 0, 1'b1);
        check("R8", rdata, 32'h0);

        // constrained random traffic
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            logic [31:0] k;
            k = $urandom % 8;
            case (k)
                0, 1, 2: a = 8'h00;
                3, 4:    a = 8'h04;
                5:       a = 8'h08;
                default: a = 8'($urandom);
            endcase
            cyc(a == 8'h00 ? "R2" : (a == 8'h04 ? "R6" : "R8"),
                NS'($urandom) & NS'($urandom), a,
                ($urandom % 4) == 0, $urandom, ($urandom % 3) != 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule